// File: doc/BRIEF.md
# Word-Time Wakeup Generator

This block turns the bit clock coming from a disk drive into one task wakeup for every completed data word. A counter in the drive clock domain counts bit clock edges. At the end of each word it flips a single toggle flop. The system clock domain brings that toggle across through two synchronizing stages and detects each change with an XOR. Every detected change arms a wakeup request, which stays raised until the word task acknowledges it. If the task falls a whole word behind, a sticky overrun flag is set.

A single allow control gates the whole path. While allow is low, the drive-side counter and toggle are held in asynchronous reset. The system-side synchronizer, request and overrun are cleared, and an init status flag is forced on. Once allow is high, the init flag stays on until the word task runs with its block (go-to-sleep) strobe asserted. After that it stays off until allow drops again. The drive-side reset is released through a two-flop synchronizer on the bit clock, so the first two bit clock edges after allow rises only release that reset.

Top module: `word_wake`

## Requirements
- R1: When the system reset is released, wake_req is 0, overrun is 0 and init_flag is 1.
- R2: While allow is low, init_flag is 1 on the following system clock edge, and task_block has no effect on it.
- R3: With allow high, a task_block pulse clears init_flag on the next system clock edge. init_flag then stays 0 while allow stays high.
- R4: After allow rises, the first word ends on the 18th rising bit_clk edge. The first two edges only release the drive-side reset. Every further word ends 16 rising edges later.
- R5: A word end raises wake_req no sooner than the second and no later than the third rising system clock edge after the bit_clk edge that ended the word.
- R6: A bit_clk edge that does not end a word causes no wakeup.
- R7: wake_req stays high until a wake_ack pulse, which clears it on the next edge. If a word ends while wake_req is still high and unacknowledged, overrun goes to 1 and stays 1 until allow goes low.
- R8: While allow is low, wake_req and overrun read 0 after the next system clock edge, and bit_clk edges produce no wakeup.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_sys | input | 1 | System clock |
| rst_sys_n | input | 1 | Asynchronous active-low reset |
| bit_clk | input | 1 | Bit clock from the drive, unrelated to clk_sys |
| allow | input | 1 | Enables word counting and wakeups; low holds all wakeup logic reset |
| task_block | input | 1 | Word task is running and going to sleep; clears init_flag |
| wake_ack | input | 1 | Word task has taken the pending wakeup |
| wake_req | output | 1 | Pending word-task wakeup request |
| overrun | output | 1 | Sticky flag: a word ended before the previous wakeup was acknowledged |
| init_flag | output | 1 | Init status; on while allow is low, until the first block |

## Verification
The hardest state to reach is overrun. Reaching it needs a second word to cross the synchronizer while the first wakeup is still unacknowledged, and then the flag must be shown to survive a later acknowledge. The stimulus withholds wake_ack at random after about a quarter of the word ends and adds one directed run of two unacknowledged words. Every bit_clk edge is placed one nanosecond after a system edge, with a random number of system cycles in between. This lets the bench check both the lower and the upper latency bound of each crossing.

// File: rtl/word_wake_pkg.sv
package word_wake_pkg;

  localparam int unsigned WORD_BITS_DEF   = 16;
  localparam int unsigned SYNC_STAGES_DEF = 2;
  localparam int unsigned RST_STAGES_DEF  = 2;

  typedef struct packed {
    logic pend;
    logic ovr;
    logic init;
  } wake_state_t;

endpackage

// File: rtl/ww_rst_sync.sv
module ww_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/ww_bit_count.sv
module ww_bit_count #(
  parameter int unsigned WORD_BITS = 16
) (
  input  logic bit_clk,
  input  logic srst_n,
  output logic word_tgl
);

  localparam int unsigned   CW   = $clog2(WORD_BITS);
  localparam logic [CW-1:0] LAST = CW'(WORD_BITS - 1);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          tgl_q;
  logic          tgl_d;
  logic          at_last;

  always_comb begin
    at_last = (cnt_q == LAST);
    cnt_d   = at_last ? '0 : cnt_q + ONE;
    tgl_d   = tgl_q ^ at_last;
  end

  always_ff @(posedge bit_clk or negedge srst_n) begin
    if (!srst_n) begin
      cnt_q <= '0;
      tgl_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tgl_q <= tgl_d;
    end
  end

  assign word_tgl = tgl_q;

endmodule

// File: rtl/ww_tgl_sync.sv
module ww_tgl_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic allow,
  input  logic tgl_async,
  output logic word_evt
);

  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb begin
    if (allow) begin
      sh_d = {sh_q[STAGES-1:0], tgl_async};
    end else begin
      sh_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign word_evt = sh_q[STAGES-1] ^ sh_q[STAGES];

  AST_EVT_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !allow |=> !word_evt) else $error("event while idle"); // R8

endmodule

// File: rtl/ww_wake_ctl.sv
module ww_wake_ctl
  import word_wake_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic allow,
  input  logic task_block,
  input  logic wake_ack,
  input  logic word_evt,
  output logic wake_req,
  output logic overrun,
  output logic init_flag
);

  wake_state_t st_q;
  wake_state_t st_d;

  always_comb begin
    st_d = st_q;
    if (!allow) begin
      st_d.pend = 1'b0;
      st_d.ovr  = 1'b0;
      st_d.init = 1'b1;
    end else begin
      if (task_block) begin
        st_d.init = 1'b0;
      end
      if (word_evt) begin
        if (st_q.pend && !wake_ack) begin
          st_d.ovr = 1'b1;
        end
        st_d.pend = 1'b1;
      end else if (wake_ack) begin
        st_d.pend = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q.pend <= 1'b0;
      st_q.ovr  <= 1'b0;
      st_q.init <= 1'b1;
    end else begin
      st_q <= st_d;
    end
  end

  assign wake_req  = st_q.pend;
  assign overrun   = st_q.ovr;
  assign init_flag = st_q.init;

  AST_INIT_WHILE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !allow |=> init_flag) else $error("init low while idle"); // R2
  AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    allow && task_block |=> !init_flag) else $error("init not cleared"); // R3
  AST_INIT_STAYS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    allow && !init_flag |=> !init_flag) else $error("init came back"); // R3
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    allow && wake_req && !wake_ack |=> wake_req) else $error("request dropped"); // R7
  AST_OVR_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(wake_req)) else $error("overrun without pending"); // R7
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    allow && overrun |=> overrun) else $error("overrun lost"); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !allow |=> !wake_req && !overrun) else $error("activity while idle"); // R8

endmodule

// File: rtl/word_wake.sv
module word_wake
  import word_wake_pkg::*;
#(
  parameter int unsigned WORD_BITS   = WORD_BITS_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF,
  parameter int unsigned RST_STAGES  = RST_STAGES_DEF
) (
  input  logic clk_sys,
  input  logic rst_sys_n,
  input  logic bit_clk,
  input  logic allow,
  input  logic task_block,
  input  logic wake_ack,
  output logic wake_req,
  output logic overrun,
  output logic init_flag
);

  logic sys_rst_n;
  logic drv_arst_n;
  logic drv_rst_n;
  logic word_tgl;
  logic word_evt;

  assign drv_arst_n = rst_sys_n & allow;

  ww_rst_sync #(.STAGES(RST_STAGES)) u_sys_rst (
    .clk    (clk_sys),
    .arst_n (rst_sys_n),
    .srst_n (sys_rst_n)
  );

  ww_rst_sync #(.STAGES(RST_STAGES)) u_drv_rst (
    .clk    (bit_clk),
    .arst_n (drv_arst_n),
    .srst_n (drv_rst_n)
  );

  ww_bit_count #(.WORD_BITS(WORD_BITS)) u_count (
    .bit_clk  (bit_clk),
    .srst_n   (drv_rst_n),
    .word_tgl (word_tgl)
  );

  ww_tgl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk_sys),
    .rst_n     (sys_rst_n),
    .allow     (allow),
    .tgl_async (word_tgl),
    .word_evt  (word_evt)
  );

  ww_wake_ctl u_ctl (
    .clk        (clk_sys),
    .rst_n      (sys_rst_n),
    .allow      (allow),
    .task_block (task_block),
    .wake_ack   (wake_ack),
    .word_evt   (word_evt),
    .wake_req   (wake_req),
    .overrun    (overrun),
    .init_flag  (init_flag)
  );

endmodule

// File: tb/word_wake_bench.sv
module word_wake_bench;

  logic clk_sys;
  logic rst_sys_n;
  logic bit_clk;
  logic allow;
  logic task_block;
  logic wake_ack;
  logic wake_req;
  logic overrun;
  logic init_flag;

  int checks;
  int errors;
  int nbits;
  bit exp_pend;
  bit exp_ovr;
  bit done;

  word_wake u_word_wake (
    .clk_sys    (clk_sys),
    .rst_sys_n  (rst_sys_n),
    .bit_clk    (bit_clk),
    .allow      (allow),
    .task_block (task_block),
    .wake_ack   (wake_ack),
    .wake_req   (wake_req),
    .overrun    (overrun),
    .init_flag  (init_flag)
  );

  initial clk_sys = 1'b0;
  always #2 clk_sys = ~clk_sys;

  function automatic bit word_end(input int n);
    return (n >= 18) && (((n - 2) % 16) == 0);
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // ack_mode: 0 never acknowledge, 1 always, 2 random (about 3 in 4)
  task automatic bit_edge(input int ack_mode);
    bit wend;
    bit do_ack;
    repeat ($urandom_range(0, 3)) @(posedge clk_sys);
    @(posedge clk_sys);
    #1 bit_clk = 1'b1;
    wend = 1'b0;
    if (allow) begin
      nbits++;
      wend = word_end(nbits);
    end
    #2;
    chk(wend ? "R5 no early wakeup" : "R6 quiet edge", wake_req, exp_pend);
    if (wend) begin
      if (exp_pend) exp_ovr = 1'b1;
      exp_pend = 1'b1;
    end
    #2 bit_clk = 1'b0;
    #8;
    if (wend) chk("R4 R5 wakeup after word end", wake_req, exp_pend);
    else if (allow) chk("R6 no wakeup mid word", wake_req, exp_pend);
    else chk("R8 no wakeup while idle", wake_req, exp_pend);
    chk("R7 overrun state", overrun, exp_ovr);
    do_ack = (ack_mode == 1) || (ack_mode == 2 && $urandom_range(0, 3) != 0);
    if (wend && do_ack) begin
      @(negedge clk_sys) wake_ack = 1'b1;
      @(negedge clk_sys) wake_ack = 1'b0;
      exp_pend = 1'b0;
      chk("R7 ack clears request", wake_req, 1'b0);
      chk("R7 overrun kept after ack", overrun, exp_ovr);
    end
  endtask

  task automatic set_allow(input logic v);
    @(negedge clk_sys) allow = v;
    nbits = 0;
    if (!v) begin
      exp_pend = 1'b0;
      exp_ovr  = 1'b0;
    end
    @(negedge clk_sys);
    @(negedge clk_sys);
  endtask

  task automatic pulse_block;
    @(negedge clk_sys) task_block = 1'b1;
    @(negedge clk_sys) task_block = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1d5a_70c3));
    checks = 0; errors = 0; nbits = 0;
    exp_pend = 1'b0; exp_ovr = 1'b0; done = 1'b0;
    rst_sys_n = 1'b0; bit_clk = 1'b0; allow = 1'b0;
    task_block = 1'b0; wake_ack = 1'b0;
    repeat (5) @(negedge clk_sys);
    rst_sys_n = 1'b1;
    repeat (4) @(negedge clk_sys);
    chk("R1 reset wake_req", wake_req, 1'b0);
    chk("R1 reset overrun", overrun, 1'b0);
    chk("R1 reset init_flag", init_flag, 1'b1);

    // R2: block strobe ignored while allow is low
    pulse_block();
    @(negedge clk_sys);
    chk("R2 init held while idle", init_flag, 1'b1);
    for (int i = 0; i < 20; i++) bit_edge(1);
    chk("R8 no overrun while idle", overrun, 1'b0);

    // R3: init stays on after allow until the task blocks
    set_allow(1'b1);
    chk("R3 init still on before block", init_flag, 1'b1);
    pulse_block();
    chk("R3 init cleared by block", init_flag, 1'b0);

    // R4: directed first words, acknowledged
    for (int i = 0; i < 50; i++) bit_edge(1);
    chk("R3 init stays clear", init_flag, 1'b0);

    // random acknowledge pattern
    for (int i = 0; i < 600; i++) bit_edge(2);

    // directed overrun: clear pending first, then two unacked words
    if (exp_pend) begin
      @(negedge clk_sys) wake_ack = 1'b1;
      @(negedge clk_sys) wake_ack = 1'b0;
      exp_pend = 1'b0;
    end
    for (int i = 0; i < 32; i++) bit_edge(0);
    chk("R7 overrun after missed word", overrun, 1'b1);
    chk("R7 request still pending", wake_req, 1'b1);
    @(negedge clk_sys) wake_ack = 1'b1;
    @(negedge clk_sys) wake_ack = 1'b0;
    exp_pend = 1'b0;
    chk("R7 ack clears request", wake_req, 1'b0);
    chk("R7 overrun sticky after ack", overrun, 1'b1);

    // R8: dropping allow clears everything
    set_allow(1'b0);
    chk("R8 request cleared", wake_req, 1'b0);
    chk("R8 overrun cleared", overrun, 1'b0);
    chk("R2 init back on", init_flag, 1'b1);
    for (int i = 0; i < 10; i++) bit_edge(1);

    // R4: count restarts from zero after allow rises again
    set_allow(1'b1);
    for (int i = 0; i < 40; i++) bit_edge(1);
    chk("R2 init on until block", init_flag, 1'b1);

    finish_run();
  end

endmodule